// File: doc/BRIEF.md
# Cipher Output Feedback Capture Stage

This block sits around a 32-bit block-cipher engine, on both of its word streams. It reverses the byte order of every word going into the engine and of every word coming out of it. Output words normally go downstream after that swap. When feedback is switched on, the output words are also captured into two shift registers, one for an initialization vector and one for a key. At the end of a packet the captured words are committed into the IV registers, the user key registers, or one of two device key slots (boot and operational).

Feedback is turned on either by four external write-control inputs or by two control-register bits. The IV capture register is chained ahead of the key capture register. While the IV is being captured, each word it displaces moves on into the key capture register. Whenever any feedback source is active, the data words sent downstream are forced to zero. Their valid and last markers still pass through. The cipher itself is outside this block.

Top module: `fb_capture_stage`

## Requirements
- R1: The upstream word goes to the engine with its bytes reversed: byte k (bits 8k+7:8k) moves to byte 3-k. Valid and last pass through unchanged, and `upReady` equals `engInReady`.
- R2: With no feedback source active, `dnData` is the engine output word with its bytes reversed. `dnValid` equals `engOutValid`, `dnLast` equals `engOutLast`, and `engOutReady` equals `dnReady`.
- R3: IV feedback is active when `wrIv` is 1 or `ctrlFb[1]` is 1. User-key feedback is active when `wrUserKey` is 1 or `ctrlFb[0]` is 1. Key feedback is active when user-key feedback, `wrBootKey` or `wrOpKey` is active. While any of these is active, `dnData` is zero and valid and last still pass through.
- R4: A beat is accepted when `engOutValid` and `dnReady` are both 1. On an accepted beat with IV feedback active, the byte-reversed word enters a 4-word IV shift register at the newest end. The oldest word it displaces is offered to the key shift register.
- R5: On an accepted beat with key feedback active, the offered word enters an 8-word key shift register at the newest end. Without IV feedback, the offered word is the byte-reversed output word itself.
- R6: On an accepted beat carrying last with IV feedback active, the IV shift register, including that beat's word, is copied to `ivOut`. Word i is at bits 32i+31:32i, and word 0 is the oldest.
- R7: On an accepted last beat with user-key feedback active, the key shift register, including that beat's effect, is copied to `userKeyOut`. Word i is at bits 32i+31:32i, and word 0 is the oldest.
- R8: On an accepted last beat, the key shift register is copied to `bootKeyOut` when `wrBootKey` is 1 and to `opKeyOut` when `wrOpKey` is 1, with the same word layout as R7. Otherwise both slots hold their values.
- R9: A beat that is not accepted changes no capture or committed register.
- R10: After reset, `ivOut`, `userKeyOut`, `bootKeyOut` and `opKeyOut` are zero, and so are both capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upData | input | 32 | Upstream word toward the engine |
| upValid | input | 1 | Upstream valid |
| upLast | input | 1 | Upstream end of packet |
| upReady | output | 1 | Upstream ready (engine input ready) |
| engInData | output | 32 | Byte-reversed word to the engine |
| engInValid | output | 1 | Valid to the engine |
| engInLast | output | 1 | Last to the engine |
| engInReady | input | 1 | Engine input ready |
| engOutData | input | 32 | Engine output word |
| engOutValid | input | 1 | Engine output valid |
| engOutLast | input | 1 | Engine output end of packet |
| engOutReady | output | 1 | Ready back to the engine output |
| dnData | output | 32 | Downstream word (zero under feedback) |
| dnValid | output | 1 | Downstream valid |
| dnLast | output | 1 | Downstream end of packet |
| dnReady | input | 1 | Downstream ready |
| wrIv | input | 1 | External IV write control |
| wrUserKey | input | 1 | External user key write control |
| wrBootKey | input | 1 | External boot key write control |
| wrOpKey | input | 1 | External operational key write control |
| ctrlFb | input | 2 | Control bits: bit 0 user key feedback, bit 1 IV feedback |
| ivOut | output | 128 | Committed IV registers |
| userKeyOut | output | 256 | Committed user key registers |
| bootKeyOut | output | 256 | Boot key slot |
| opKeyOut | output | 256 | Operational key slot |

## Verification
The bench sends a 12-word packet with both IV and user-key feedback active. The IV must end up holding the last four words and the key the first eight. A design without the chain, or with it reversed, would put the last eight words into the key instead. Random downstream stalls probe whether a stalled beat still shifts; such a design would commit shifted or duplicated words. The bench also covers a single-word packet whose last beat is also its first, and checks that the word's own value lands in the newest slot on commit rather than a stale one. Forwarded data is compared against zero for every feedback source alone, so a leak that missed the boot or operational write inputs would show up as nonzero data.

// File: rtl/fb_capture_pkg.sv
package fb_capture_pkg;
  typedef struct packed {
    logic shiftIv;
    logic shiftKey;
    logic commitIv;
    logic commitUser;
    logic commitBoot;
    logic commitOp;
    logic zeroOut;
  } fbStrobes_t;
endpackage

// File: rtl/fb_capture_ctrl.sv
module fb_capture_ctrl
  import fb_capture_pkg::*;
(
  input  logic       wrIv,
  input  logic       wrUserKey,
  input  logic       wrBootKey,
  input  logic       wrOpKey,
  input  logic [1:0] ctrlFb,
  input  logic       engOutValid,
  input  logic       engOutLast,
  input  logic       dnReady,
  output fbStrobes_t strb
);
  logic ivFb, userFb, keyFb, beat, endBeat;

  always_comb begin
    ivFb    = wrIv | ctrlFb[1];
    userFb  = wrUserKey | ctrlFb[0];
    keyFb   = userFb | wrBootKey | wrOpKey;
    beat    = engOutValid & dnReady;
    endBeat = beat & engOutLast;
    strb.shiftIv    = beat & ivFb;
    strb.shiftKey   = beat & keyFb;
    strb.commitIv   = endBeat & ivFb;
    strb.commitUser = endBeat & userFb;
    strb.commitBoot = endBeat & wrBootKey;
    strb.commitOp   = endBeat & wrOpKey;
    strb.zeroOut    = ivFb | keyFb;
  end
endmodule

// File: rtl/fb_capture_datapath.sv
module fb_capture_datapath
  import fb_capture_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int IV_WORDS  = 4,
  parameter int KEY_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fbStrobes_t                    strb,
  input  logic [WORD_W-1:0]             upData,
  input  logic [WORD_W-1:0]             engOutData,
  output logic [WORD_W-1:0]             engInData,
  output logic [WORD_W-1:0]             dnData,
  output logic [IV_WORDS*WORD_W-1:0]    ivOut,
  output logic [KEY_WORDS*WORD_W-1:0]   userKeyOut,
  output logic [KEY_WORDS*WORD_W-1:0]   bootKeyOut,
  output logic [KEY_WORDS*WORD_W-1:0]   opKeyOut
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] dnSwap, offered;
  logic [IV_WORDS-1:0][WORD_W-1:0]  ivSh, ivNext, ivReg;
  logic [KEY_WORDS-1:0][WORD_W-1:0] keySh, keyNext, userReg, bootReg, opReg;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign engInData[b*8 +: 8] = upData[(NBYTES-1-b)*8 +: 8];
    assign dnSwap[b*8 +: 8]    = engOutData[(NBYTES-1-b)*8 +: 8];
  end

  assign dnData  = strb.zeroOut ? '0 : dnSwap;
  assign offered = strb.shiftIv ? ivSh[0] : dnSwap;

  always_comb begin
    ivNext  = ivSh;
    keyNext = keySh;
    if (strb.shiftIv) begin
      for (int i = 0; i < IV_WORDS-1; i++) ivNext[i] = ivSh[i+1];
      ivNext[IV_WORDS-1] = dnSwap;
    end
    if (strb.shiftKey) begin
      for (int i = 0; i < KEY_WORDS-1; i++) keyNext[i] = keySh[i+1];
      keyNext[KEY_WORDS-1] = offered;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ivSh    <= '0;
      keySh   <= '0;
      ivReg   <= '0;
      userReg <= '0;
      bootReg <= '0;
      opReg   <= '0;
    end else begin
      ivSh  <= ivNext;
      keySh <= keyNext;
      if (strb.commitIv)   ivReg   <= ivNext;
      if (strb.commitUser) userReg <= keyNext;
      if (strb.commitBoot) bootReg <= keyNext;
      if (strb.commitOp)   opReg   <= keyNext;
    end
  end

  assign ivOut      = ivReg;
  assign userKeyOut = userReg;
  assign bootKeyOut = bootReg;
  assign opKeyOut   = opReg;

  // R9: no IV shift strobe leaves the IV capture untouched
  p_iv_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftIv |=> $stable(ivSh));
  // R4: the word leaving the IV register is the newest key word
  p_chain_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shiftIv && strb.shiftKey) |=> keySh[KEY_WORDS-1] == $past(ivSh[0]));
  // R5: without IV feedback the raw swapped word enters the key register
  p_raw_key_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.shiftIv && strb.shiftKey) |=> keySh[KEY_WORDS-1] == $past(dnSwap));
  // R6: a committed IV equals the capture contents after that beat
  p_iv_commit_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitIv |=> ivReg == ivSh);
  // R7: a committed user key equals the key capture after that beat
  p_user_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitUser |=> userReg == keySh);
  // R8: boot slot holds unless committed
  p_boot_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitBoot |=> $stable(bootReg));
endmodule

// File: rtl/fb_capture_stage.sv
module fb_capture_stage
  import fb_capture_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int IV_WORDS  = 4,
  parameter int KEY_WORDS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [WORD_W-1:0]           upData,
  input  logic                        upValid,
  input  logic                        upLast,
  output logic                        upReady,
  output logic [WORD_W-1:0]           engInData,
  output logic                        engInValid,
  output logic                        engInLast,
  input  logic                        engInReady,
  input  logic [WORD_W-1:0]           engOutData,
  input  logic                        engOutValid,
  input  logic                        engOutLast,
  output logic                        engOutReady,
  output logic [WORD_W-1:0]           dnData,
  output logic                        dnValid,
  output logic                        dnLast,
  input  logic                        dnReady,
  input  logic                        wrIv,
  input  logic                        wrUserKey,
  input  logic                        wrBootKey,
  input  logic                        wrOpKey,
  input  logic [1:0]                  ctrlFb,
  output logic [IV_WORDS*WORD_W-1:0]  ivOut,
  output logic [KEY_WORDS*WORD_W-1:0] userKeyOut,
  output logic [KEY_WORDS*WORD_W-1:0] bootKeyOut,
  output logic [KEY_WORDS*WORD_W-1:0] opKeyOut
);
  fbStrobes_t strb;

  assign upReady     = engInReady;
  assign engInValid  = upValid;
  assign engInLast   = upLast;
  assign dnValid     = engOutValid;
  assign dnLast      = engOutLast;
  assign engOutReady = dnReady;

  fb_capture_ctrl u_ctrl (
    .wrIv(wrIv), .wrUserKey(wrUserKey), .wrBootKey(wrBootKey), .wrOpKey(wrOpKey),
    .ctrlFb(ctrlFb), .engOutValid(engOutValid), .engOutLast(engOutLast),
    .dnReady(dnReady), .strb(strb)
  );

  fb_capture_datapath #(.WORD_W(WORD_W), .IV_WORDS(IV_WORDS), .KEY_WORDS(KEY_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .upData(upData), .engOutData(engOutData),
    .engInData(engInData), .dnData(dnData), .ivOut(ivOut), .userKeyOut(userKeyOut),
    .bootKeyOut(bootKeyOut), .opKeyOut(opKeyOut)
  );

  // R3: any feedback source blanks forwarded data at the port
  p_zero_fwd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && (wrIv || wrUserKey || wrBootKey || wrOpKey || (ctrlFb != 2'b00)))
      |-> dnData == '0);
endmodule

// File: tb/fb_capture_stage_bench.sv
module fb_capture_stage_bench;
  localparam int W = 32, NI = 4, NK = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic [W-1:0] upData = '0, engInData, engOutData = '0, dnData;
  logic upValid = 0, upLast = 0, upReady, engInValid, engInLast, engInReady = 0;
  logic engOutValid = 0, engOutLast = 0, engOutReady, dnValid, dnLast, dnReady = 0;
  logic wrIv = 0, wrUserKey = 0, wrBootKey = 0, wrOpKey = 0;
  logic [1:0] ctrlFb = '0;
  logic [NI*W-1:0] ivOut;
  logic [NK*W-1:0] userKeyOut, bootKeyOut, opKeyOut;

  fb_capture_stage u_fb_capture_stage (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [NI-1:0][W-1:0] mIvSh = '0, mIv = '0;
  logic [NK-1:0][W-1:0] mKeySh = '0, mUser = '0, mBoot = '0, mOp = '0;
  logic [W-1:0] recv [16];
  int cnt, plen;

  function automatic logic [W-1:0] swap32(logic [W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic void model_beat();
    logic [W-1:0] w, off;
    logic ivFb, uFb, kFb;
    w = swap32(engOutData);
    ivFb = wrIv | ctrlFb[1];
    uFb = wrUserKey | ctrlFb[0];
    kFb = uFb | wrBootKey | wrOpKey;
    off = w;
    if (ivFb) begin
      off = mIvSh[0];
      for (int i = 0; i < NI-1; i++) mIvSh[i] = mIvSh[i+1];
      mIvSh[NI-1] = w;
    end
    if (kFb) begin
      for (int i = 0; i < NK-1; i++) mKeySh[i] = mKeySh[i+1];
      mKeySh[NK-1] = off;
    end
    if (engOutLast) begin
      if (ivFb) mIv = mIvSh;
      if (uFb) mUser = mKeySh;
      if (wrBootKey) mBoot = mKeySh;
      if (wrOpKey) mOp = mKeySh;
    end
  endfunction

  task automatic cycle(bit force_flow);
    bit acc, anyFb;
    @(negedge clk);
    upData = $urandom; upValid = $urandom % 2; upLast = $urandom % 2;
    engInReady = $urandom % 2;
    engOutData = $urandom;
    engOutValid = force_flow ? 1'b1 : (($urandom % 5) != 0);
    dnReady = force_flow ? 1'b1 : (($urandom % 4) != 0);
    engOutLast = (cnt == plen - 1);
    #1;
    chk("R1 engInData", engInData, swap32(upData));
    chk("R1 valid/last/ready", {engInValid, engInLast, upReady}, {upValid, upLast, engInReady});
    anyFb = wrIv | wrUserKey | wrBootKey | wrOpKey | (ctrlFb != 0);
    chk(anyFb ? "R3 dnData zero" : "R2 dnData swap", dnData, anyFb ? '0 : swap32(engOutData));
    chk("R2 valid/last/ready", {dnValid, dnLast, engOutReady}, {engOutValid, engOutLast, dnReady});
    acc = engOutValid && dnReady;
    @(posedge clk);
    if (acc) begin
      model_beat();
      recv[cnt] = engOutData;
      cnt++;
    end
    #1;
    chk("R6/R9 ivOut", ivOut, mIv);
    chk("R7/R9 userKeyOut", userKeyOut, mUser);
    chk("R8/R9 bootKeyOut", bootKeyOut, mBoot);
    chk("R8/R9 opKeyOut", opKeyOut, mOp);
  endtask

  task automatic packet(logic [3:0] wr, logic [1:0] fb, int len, bit force_flow);
    @(negedge clk);
    engOutValid = 0;
    {wrIv, wrUserKey, wrBootKey, wrOpKey} = wr;
    ctrlFb = fb;
    cnt = 0; plen = len;
    while (cnt < plen) cycle(force_flow);
  endtask

  initial begin
    #(150000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 ivOut reset", ivOut, '0);
    chk("R10 userKeyOut reset", userKeyOut, '0);
    chk("R10 boot/op reset", {bootKeyOut, opKeyOut}, '0);
    @(negedge clk); rstN = 1;
    void'($urandom(32'h5EED_1234));

    // R4 and R6 and R7: chained capture, 12 words with IV and user key feedback
    packet(4'b1100, 2'b00, 12, 1'b1);
    for (int i = 0; i < NI; i++) chk("R4 R6 iv word from tail", ivOut[i*W +: W], swap32(recv[8+i]));
    for (int i = 0; i < NK; i++) chk("R4 R7 key word from head", userKeyOut[i*W +: W], swap32(recv[i]));
    // R5: user key only through control bit 0, raw words
    packet(4'b0000, 2'b01, 8, 1'b0);
    for (int i = 0; i < NK; i++) chk("R5 raw key word", userKeyOut[i*W +: W], swap32(recv[i]));
    // R6: IV only through control bit 1, single-word packet
    packet(4'b0000, 2'b10, 1, 1'b1);
    chk("R6 single beat newest", ivOut[3*W +: W], swap32(recv[0]));
    // R8: boot and operational slots
    packet(4'b0010, 2'b00, 8, 1'b0);
    chk("R8 boot slot", bootKeyOut, mBoot);
    packet(4'b0001, 2'b00, 5, 1'b0);
    chk("R8 op slot", opKeyOut, mOp);
    // R2: no feedback
    packet(4'b0000, 2'b00, 6, 1'b0);

    for (int p = 0; p < 400; p++) begin
      logic [3:0] wr;
      logic [1:0] fb;
      for (int b = 0; b < 4; b++) wr[b] = ($urandom % 3) == 0;
      for (int b = 0; b < 2; b++) fb[b] = ($urandom % 3) == 0;
      packet(wr, fb, 1 + ($urandom % 14), 1'b0);
    end
    finish_run();
  end
endmodule